// File: doc/BRIEF.md
# Debug-Port Serial Receiver with Status Flags

This block receives asynchronous serial characters on a single line for a debug port. An outside enable pulses at sixteen times the baud rate. Each pulse is one sample tick. A falling edge on the line only counts as a start bit if the line is still low half a bit later. A short low pulse is dropped as noise. After a start bit is confirmed, the block takes one sample per full bit period, near the middle of each bit. It collects eight data bits, an optional parity bit and one stop bit.

Each finished character is copied into a holding register and raises a ready flag. A one-cycle read strobe on the holding register clears the ready flag. If a new character arrives while the ready flag is still set, it overwrites the holding register and sets a sticky overrun flag. A parity mismatch sets a sticky parity-error flag. Both sticky flags stay set until a reset-status strobe clears them. A three-bit mode input chooses the parity check.

Top module: `dbg_uart_rx`

## Requirements
- R1: A falling edge on `rx_in` starts a character only if the line is still low 8 sample ticks later. A low pulse that has ended by that point changes no output.
- R2: Data bits arrive least-significant first. Each bit lasts 16 sample ticks and is sampled once. The eight bits form `hold_data`, with the first bit received in bit 0.
- R3: When the stop bit has been sampled, `hold_data` takes the new character and `rx_ready` goes to 1.
- R4: A one-cycle pulse on `rd_hold` clears `rx_ready` and leaves `hold_data` unchanged.
- R5: If a character completes while `rx_ready` is 1 and `rd_hold` is not pulsed in that cycle, `ovr_flag` goes to 1 and `hold_data` is replaced by the new character.
- R6: `ovr_flag` stays 1 until a pulse on `rst_sts` clears it. `rst_sts` does not change `rx_ready`.
- R7: `par_mode` selects the expected parity bit: 0 gives even parity over the data, 1 gives odd parity, 2 always expects 0 and 3 always expects 1. A received parity bit that differs from the expected value sets `par_err`. `par_err` stays 1 until a pulse on `rst_sts` clears it.
- R8: With `par_mode` at 4 (and also at 5 to 7), no parity bit is in the frame. The stop bit directly follows D7, and `par_err` is never set.
- R9: After reset, `rx_ready`, `ovr_flag`, `par_err` and `hold_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Sample tick, 16 per bit period |
| rx_in | input | 1 | Serial line, idle high |
| rd_hold | input | 1 | Read strobe for the holding register |
| rst_sts | input | 1 | Reset-status strobe for the sticky flags |
| par_mode | input | 3 | Parity mode: 0 even, 1 odd, 2 forced 0, 3 forced 1, 4 to 7 none |
| hold_data | output | 8 | Receive holding register |
| rx_ready | output | 1 | A character is waiting in the holding register |
| ovr_flag | output | 1 | Sticky overrun flag |
| par_err | output | 1 | Sticky parity-error flag |

## Verification
The hardest case to produce from the ports is a character that lands on a set ready flag while the sticky flags already hold state from earlier frames. This is the only case that shows whether overrun, parity error and ready are updated independently of each other. The stimulus sends characters back to back with no read in between. It does this with forced-parity modes and deliberately wrong parity bits. It then issues reset-status strobes while the ready flag is still up, and a scoreboard model follows all three flags across the whole sequence. Noise pulses of 4 and 6 ticks check that start qualification rejects them. A no-parity frame sent straight after a parity frame checks the bit count.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        PAR_EVEN = 3'd0,
        PAR_ODD  = 3'd1,
        PAR_ZERO = 3'd2,
        PAR_ONE  = 3'd3,
        PAR_NONE = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_bad;
    } rx_char_t;

    // Modes 4..7 carry no parity bit.
    function automatic logic parity_used(input logic [2:0] mode);
        return mode < 3'd4;
    endfunction

    function automatic logic parity_expect(input logic [2:0] mode,
                                           input logic [CHAR_W-1:0] d);
        case (mode)
            3'd0:    return ^d;
            3'd1:    return ~(^d);
            3'd2:    return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       samp_en,
    input  logic       rx,
    input  logic [2:0] par_mode,
    output logic       done,
    output rx_char_t   chr
);
    localparam int CNT_W = $clog2(OVS);
    localparam int HALF  = OVS / 2;
    localparam int BIT_W = $clog2(CHAR_W);
    localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF - 1);
    localparam logic [CNT_W-1:0] FULL_END = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAR_W - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bidx;
    logic [CHAR_W-1:0] shreg;
    logic              rx_prev;
    logic              pbad;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bidx    <= '0;
            shreg   <= '0;
            rx_prev <= 1'b1;
            pbad    <= 1'b0;
            done    <= 1'b0;
            chr     <= '0;
        end else begin
            done <= 1'b0;
            if (samp_en) begin
                rx_prev <= rx;
                case (state)
                    ST_IDLE: begin
                        if (rx_prev && !rx) begin
                            state <= ST_START;
                            cnt   <= '0;
                            pbad  <= 1'b0;
                        end
                    end
                    ST_START: begin
                        if (cnt == HALF_END) begin
                            cnt   <= '0;
                            bidx  <= '0;
                            state <= rx ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == FULL_END) begin
                            cnt   <= '0;
                            shreg <= {rx, shreg[CHAR_W-1:1]};
                            if (bidx == LAST_BIT)
                                state <= parity_used(par_mode) ? ST_PAR : ST_STOP;
                            else
                                bidx <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == FULL_END) begin
                            cnt   <= '0;
                            pbad  <= (rx != parity_expect(par_mode, shreg));
                            state <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == FULL_END) begin
                            cnt         <= '0;
                            done        <= 1'b1;
                            chr.data    <= shreg;
                            chr.par_bad <= parity_used(par_mode) && pbad;
                            state       <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_char_t          chr,
    input  logic              rd_hold,
    input  logic              rst_sts,
    output logic [CHAR_W-1:0] hold_data,
    output logic              rdy,
    output logic              ovr,
    output logic              perr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data <= '0;
            rdy       <= 1'b0;
            ovr       <= 1'b0;
            perr      <= 1'b0;
        end else begin
            if (done) begin
                hold_data <= chr.data;
                rdy       <= 1'b1;
            end else if (rd_hold) begin
                rdy <= 1'b0;
            end

            // A read in the same cycle consumes the old character.
            if (done && rdy && !rd_hold) ovr <= 1'b1;
            else if (rst_sts)            ovr <= 1'b0;

            if (done && chr.par_bad) perr <= 1'b1;
            else if (rst_sts)        perr <= 1'b0;
        end
    end
endmodule

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       samp_en,
    input  logic       rx_in,
    input  logic       rd_hold,
    input  logic       rst_sts,
    input  logic [2:0] par_mode,
    output logic [7:0] hold_data,
    output logic       rx_ready,
    output logic       ovr_flag,
    output logic       par_err
);
    logic     rx_s;
    logic     frm_done;
    rx_char_t frm_chr;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (rx_s)
    );

    uart_rx_frame #(.OVS(OVS)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .samp_en  (samp_en),
        .rx       (rx_s),
        .par_mode (par_mode),
        .done     (frm_done),
        .chr      (frm_chr)
    );

    uart_rx_status u_status (
        .clk       (clk),
        .rst       (rst),
        .done      (frm_done),
        .chr       (frm_chr),
        .rd_hold   (rd_hold),
        .rst_sts   (rst_sts),
        .hold_data (hold_data),
        .rdy       (rx_ready),
        .ovr       (ovr_flag),
        .perr      (par_err)
    );
endmodule

// File: rtl/dbg_uart_rx_chk.sv
module dbg_uart_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_hold,
    input logic       rst_sts,
    input logic [2:0] par_mode,
    input logic       frm_done,
    input logic [7:0] frm_data,
    input logic [7:0] hold_data,
    input logic       rx_ready,
    input logic       ovr_flag,
    input logic       par_err
);
    p_ready_on_char_r3: assert property (@(posedge clk) disable iff (rst)
        frm_done |=> (rx_ready && hold_data == $past(frm_data)));

    p_ready_source_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> $past(frm_done));

    p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_hold && !frm_done) |=> (!rx_ready && $stable(hold_data)));

    p_overrun_set_r5: assert property (@(posedge clk) disable iff (rst)
        (frm_done && rx_ready && !rd_hold) |=> ovr_flag);

    p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !rst_sts) |=> ovr_flag);

    p_status_keeps_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (rst_sts && !rd_hold && !frm_done) |=> $stable(rx_ready));

    p_perr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (par_err && !rst_sts) |=> par_err);

    p_no_parity_r8: assert property (@(posedge clk) disable iff (rst)
        (par_mode >= 3'd4 && !par_err) |=> !par_err);
endmodule

bind dbg_uart_rx dbg_uart_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_hold   (rd_hold),
    .rst_sts   (rst_sts),
    .par_mode  (par_mode),
    .frm_done  (frm_done),
    .frm_data  (frm_chr.data),
    .hold_data (hold_data),
    .rx_ready  (rx_ready),
    .ovr_flag  (ovr_flag),
    .par_err   (par_err)
);

// File: tb/dbg_uart_rx_bench.sv
module dbg_uart_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       samp_en = 1'b0;
    logic       rx_in = 1'b1;
    logic       rd_hold = 1'b0;
    logic       rst_sts = 1'b0;
    logic [2:0] par_mode = 3'd0;
    logic [7:0] hold_data;
    logic       rx_ready, ovr_flag, par_err;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] data;
        logic       rdy;
        logic       ovr;
        logic       perr;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    logic [7:0] m_data = 8'h00;
    logic       m_rdy = 1'b0, m_ovr = 1'b0, m_perr = 1'b0;

    dbg_uart_rx u_dbg_uart_rx (
        .clk       (clk),
        .rst       (rst),
        .samp_en   (samp_en),
        .rx_in     (rx_in),
        .rd_hold   (rd_hold),
        .rst_sts   (rst_sts),
        .par_mode  (par_mode),
        .hold_data (hold_data),
        .rx_ready  (rx_ready),
        .ovr_flag  (ovr_flag),
        .par_err   (par_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            samp_en = ~samp_en;
        end
    end

    task automatic cmp1(string tag, string name, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0b exp %0b", tag, name, got, exp);
        end
    endtask

    // Monitor: pops expected items and compares against the ports.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                checks++;
                if (hold_data !== it.data) begin
                    errors++;
                    $display("FAIL %s hold_data got %02h exp %02h", it.tag, hold_data, it.data);
                end
                cmp1(it.tag, "rx_ready", rx_ready, it.rdy);
                cmp1(it.tag, "ovr_flag", ovr_flag, it.ovr);
                cmp1(it.tag, "par_err", par_err, it.perr);
            end
        end
    end

    task automatic push_exp(string tag);
        exp_t it;
        it.data = m_data; it.rdy = m_rdy; it.ovr = m_ovr; it.perr = m_perr; it.tag = tag;
        sb_q.push_back(it);
        repeat (3) @(negedge clk);
    endtask

    task automatic drive_bit(logic b);
        rx_in = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(logic [7:0] d, logic [2:0] mode, bit bad_par, string tag);
        logic pb;
        par_mode = mode;
        case (mode)
            3'd0:    pb = ^d;
            3'd1:    pb = ~(^d);
            3'd2:    pb = 1'b0;
            default: pb = 1'b1;
        endcase
        if (bad_par) pb = ~pb;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (mode < 3'd4) drive_bit(pb);
        drive_bit(1'b1);
        if (m_rdy) m_ovr = 1'b1;
        m_rdy  = 1'b1;
        m_data = d;
        if (mode < 3'd4 && bad_par) m_perr = 1'b1;
        push_exp(tag);
    endtask

    task automatic glitch(int clks, string tag);
        rx_in = 1'b0;
        repeat (clks) @(negedge clk);
        rx_in = 1'b1;
        repeat (BIT_CLKS * 2) @(negedge clk);
        push_exp(tag);
    endtask

    task automatic do_read(string tag);
        rd_hold = 1'b1;
        @(negedge clk);
        rd_hold = 1'b0;
        m_rdy = 1'b0;
        push_exp(tag);
    endtask

    task automatic do_rst_sts(string tag);
        rst_sts = 1'b1;
        @(negedge clk);
        rst_sts = 1'b0;
        m_ovr  = 1'b0;
        m_perr = 1'b0;
        push_exp(tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        push_exp("R9");                          // reset state

        glitch(8, "R1");                         // 4-tick low pulse
        glitch(12, "R1");                        // 6-tick low pulse

        send_frame(8'hA5, 3'd0, 0, "R2");        // even, good
        send_frame(8'h01, 3'd0, 0, "R3");        // overrun too: model tracks it
        do_rst_sts("R6");                        // ready stays 1
        do_read("R4");
        send_frame(8'h3C, 3'd1, 0, "R3");        // odd, good
        send_frame(8'h81, 3'd0, 0, "R5");        // no read: overrun, overwrite
        send_frame(8'h7E, 3'd1, 0, "R6");        // overrun still sticky
        do_rst_sts("R6");
        send_frame(8'h0F, 3'd2, 1, "R7");        // forced 0, wrong bit
        send_frame(8'hF0, 3'd0, 0, "R7");        // perr stays sticky
        do_read("R4");
        do_rst_sts("R7");
        send_frame(8'h55, 3'd3, 0, "R7");        // forced 1, good
        do_read("R4");
        send_frame(8'h96, 3'd1, 1, "R7");        // odd, wrong bit
        do_read("R4");
        do_rst_sts("R7");
        send_frame(8'h5A, 3'd4, 0, "R8");        // no parity bit
        send_frame(8'hC3, 3'd7, 1, "R8");        // mode 7: no parity either
        do_read("R4");
        do_rst_sts("R6");
        send_frame(8'h6B, 3'd0, 1, "R7");        // even, wrong bit
        glitch(10, "R1");

        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule